// File: doc/BRIEF.md
# Supply Latch-Up Event Monitor and Power Restorer

The block watches the latch-up indicator lines of two supplies, one analog and one digital. An indicator goes high when its supply has seen overcurrent and switched itself off. For each such trip the block commits an event. It notes which supply tripped, stamps the event with the value of a free-running time base, and computes the interval since the previous event from either supply. It then restores power by asserting a restore request for that supply, which forces the control line to logic 0. A programmable hold-off delay runs first, and the request is then held for a fixed number of cycles.

An event whose interval is shorter than a programmable minimum is marked as fast. Such an event suggests that the supply is oscillating between being reset and latching again, and it would bias a rate measurement. After a set number of fast events in a row, the block enters lockout and starts no further restores until an external clear arrives.

Events wait in a small queue that is read head-first. A saturating event counter for each supply can be read at any time.

Top module: `lu_guard`

## Requirements
- R1: After reset, both restore outputs are low, the queue is empty, both counters read zero and lockout is off.
- R2: An indicator must read high on two consecutive synchronized samples before an event is committed. A high pulse that lasts one clock cycle creates no event, no count and no restore.
- R3: When an event reaches an empty queue with no contention, the restore output of its supply rises exactly `holdoff_i` cycles after `ev_valid_o` rises. A hold-off of 0 means both rise in the same cycle.
- R4: A restore stays high for exactly RESTORE_CYC cycles. The channel then re-arms, and a later trip creates a new event.
- R5: Each record carries the supply code (0 for analog, 1 for digital) and the time base value at commit. It also carries the interval, which is the stamp minus the previous record's stamp modulo 2^TW. The first record after reset carries an interval of all ones.
- R6: When both indicators commit in the same cycle, both restores start together. The analog record is logged first, and the digital record follows with the same stamp and an interval of 0.
- R7: A record's fast flag is 1 exactly when a previous record exists and its interval is below `min_gap_i`.
- R8: After LOCK_N consecutive fast records, `locked_o` goes high and no restore begins while it stays high. A pulse on `lock_clr_i` ends the lockout, and any restore that was held back then completes.
- R9: The queue holds DEPTH records, and `ev_pop_i` removes the head. A record that arrives while the queue is full is discarded, but it is still counted.
- R10: Each supply's counter increments once per logged event and saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trip_i | input | 2 | Latch-up indicators, bit 0 analog, bit 1 digital |
| restore_o | output | 2 | Restore request for each supply (forces the control line low) |
| tbase_i | input | TW | Free-running time base |
| holdoff_i | input | HW | Cycles to wait between commit and restore |
| min_gap_i | input | TW | Intervals below this value count as fast |
| lock_clr_i | input | 1 | Ends the lockout |
| locked_o | output | 1 | Lockout active |
| ev_valid_o | output | 1 | The queue head holds a record |
| ev_pop_i | input | 1 | Removes the head record |
| ev_supply_o | output | 1 | Head record supply code (0 analog, 1 digital) |
| ev_stamp_o | output | TW | Head record time stamp |
| ev_gap_o | output | TW | Head record interval |
| ev_fast_o | output | 1 | Head record fast flag |
| cnt_ana_o | output | CW | Analog event count |
| cnt_dig_o | output | CW | Digital event count |

## Verification
The case that needs care is the two channels committing in the same cycle. Their restore timers then run side by side, while the single logging path has to handle both records one after the other. The bench raises both indicators at the same falling edge with the time base frozen. It checks that both restores rise at the same sample, that the analog record comes out ahead of the digital one, and that both records carry the same stamp. It also checks that the digital record has an interval of zero and is flagged fast against a nonzero minimum.

// File: rtl/lu_guard_pkg.sv
package lu_guard_pkg;
  localparam int NSUP    = 2;
  localparam int SUP_ANA = 0;
  localparam int SUP_DIG = 1;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_HOLD  = 2'd1,
    CH_DRIVE = 2'd2
  } ch_state_e;
endpackage

// File: rtl/lu_guard_chan.sv
module lu_guard_chan
  import lu_guard_pkg::*;
#(
  parameter int HW          = 8,
  parameter int RESTORE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trip_i,
  input  logic [HW-1:0] holdoff_i,
  input  logic          block_i,
  output logic          commit_o,
  output logic          restore_o
);
  localparam int RW  = (RESTORE_CYC > 1) ? $clog2(RESTORE_CYC) : 1;
  localparam int TCW = (HW > RW) ? HW : RW;

  logic            s1_q, s2_q, seen_q;
  ch_state_e       st_q;
  logic [TCW-1:0]  tmr_q;

  // two-stage synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= trip_i;
      s2_q <= s1_q;
    end
  end

  // glitch filter: two consecutive high samples while armed
  assign commit_o  = (st_q == CH_IDLE) && s2_q && seen_q;
  assign restore_o = (st_q == CH_DRIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CH_IDLE;
      tmr_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      case (st_q)
        CH_IDLE: begin
          seen_q <= s2_q;
          if (commit_o) begin
            st_q   <= CH_HOLD;
            tmr_q  <= TCW'(holdoff_i);
            seen_q <= 1'b0;
          end
        end
        CH_HOLD: begin
          if (tmr_q == '0) begin
            if (!block_i) begin
              st_q  <= CH_DRIVE;
              tmr_q <= TCW'(RESTORE_CYC - 1);
            end
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        CH_DRIVE: begin
          if (tmr_q == '0) st_q <= CH_IDLE;
          else             tmr_q <= tmr_q - 1'b1;
        end
        default: st_q <= CH_IDLE;
      endcase
    end
  end

  // R2: a commit needs the raw line high at two successive sampling edges
  a_r2_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> ($past(trip_i, 2) && $past(trip_i, 3)));

  // R4: a restore never starts without a committed event in hold
  a_r4_restore_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restore_o) |-> !$past(commit_o));
endmodule

// File: rtl/lu_guard_fifo.sv
module lu_guard_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [NW-1:0] num_q;
  logic          full_w, do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_w  = (num_q == NW'(DEPTH));
  assign valid_o = (num_q != '0);
  assign do_push = push_i && !full_w;
  assign do_pop  = pop_i && valid_o;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      num_q <= '0;
    end else begin
      if (do_push) wr_q <= ptr_next(wr_q);
      if (do_pop)  rd_q <= ptr_next(rd_q);
      case ({do_push, do_pop})
        2'b10:   num_q <= num_q + 1'b1;
        2'b01:   num_q <= num_q - 1'b1;
        default: num_q <= num_q;
      endcase
    end
  end

  // R9: occupancy never exceeds the depth
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    num_q <= NW'(DEPTH));

  // R9: the head record only changes on a pop
  a_r9_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !pop_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/lu_guard.sv
module lu_guard
  import lu_guard_pkg::*;
#(
  parameter int TW          = 16,
  parameter int HW          = 8,
  parameter int CW          = 8,
  parameter int DEPTH       = 4,
  parameter int RESTORE_CYC = 4,
  parameter int LOCK_N      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    trip_i,
  output logic [1:0]    restore_o,
  input  logic [TW-1:0] tbase_i,
  input  logic [HW-1:0] holdoff_i,
  input  logic [TW-1:0] min_gap_i,
  input  logic          lock_clr_i,
  output logic          locked_o,
  output logic          ev_valid_o,
  input  logic          ev_pop_i,
  output logic          ev_supply_o,
  output logic [TW-1:0] ev_stamp_o,
  output logic [TW-1:0] ev_gap_o,
  output logic          ev_fast_o,
  output logic [CW-1:0] cnt_ana_o,
  output logic [CW-1:0] cnt_dig_o
);
  localparam int EW = 2 + 2 * TW;
  localparam int SW = $clog2(LOCK_N + 1);

  // interval between stamps, all ones when no earlier record exists
  function automatic logic [TW-1:0] gap_of(input logic [TW-1:0] now,
                                           input logic [TW-1:0] prev,
                                           input logic          first);
    return first ? '1 : (now - prev);
  endfunction

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  logic [NSUP-1:0] commit_w, pend_q, serve_oh;
  logic [TW-1:0]   stamp_q [NSUP];
  logic [CW-1:0]   cnt_q   [NSUP];
  logic            block_w, serve_any, serve_sup;
  logic [TW-1:0]   log_stamp, log_gap, last_q;
  logic            log_fast, have_prev_q, lock_set, locked_q;
  logic [SW-1:0]   streak_q;
  logic [EW-1:0]   push_rec, head_rec;

  for (genvar i = 0; i < NSUP; i++) begin : g_sup
    lu_guard_chan #(.HW(HW), .RESTORE_CYC(RESTORE_CYC)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .trip_i   (trip_i[i]),
      .holdoff_i(holdoff_i),
      .block_i  (block_w),
      .commit_o (commit_w[i]),
      .restore_o(restore_o[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stamp_q[i] <= '0;
        pend_q[i]  <= 1'b0;
        cnt_q[i]   <= '0;
      end else begin
        if (commit_w[i]) stamp_q[i] <= tbase_i;
        pend_q[i] <= (pend_q[i] && !serve_oh[i]) || commit_w[i];
        if (serve_oh[i]) cnt_q[i] <= sat_inc(cnt_q[i]);
      end
    end

    // R10: a counter never moves backwards
    a_r10_cnt_mono: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[i] >= $past(cnt_q[i]));

    // R8: no restore begins from a locked state
    a_r8_no_restore_locked: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(restore_o[i]) |-> !$past(locked_q));
  end

  // fixed priority: analog record is logged before digital
  assign serve_any = |pend_q;
  assign serve_sup = !pend_q[SUP_ANA];
  assign serve_oh  = pend_q[SUP_ANA] ? 2'b01 : (pend_q[SUP_DIG] ? 2'b10 : 2'b00);

  assign log_stamp = stamp_q[serve_sup];
  assign log_gap   = gap_of(log_stamp, last_q, !have_prev_q);
  assign log_fast  = have_prev_q && (log_gap < min_gap_i);
  assign lock_set  = serve_any && log_fast && ((streak_q + 1'b1) >= SW'(LOCK_N));
  assign block_w   = locked_q || lock_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q      <= '0;
      have_prev_q <= 1'b0;
      streak_q    <= '0;
      locked_q    <= 1'b0;
    end else begin
      if (serve_any) begin
        last_q      <= log_stamp;
        have_prev_q <= 1'b1;
      end
      if (lock_clr_i) begin
        locked_q <= 1'b0;
        streak_q <= '0;
      end else begin
        if (lock_set) locked_q <= 1'b1;
        if (serve_any) begin
          if (!log_fast)                   streak_q <= '0;
          else if (streak_q != SW'(LOCK_N)) streak_q <= streak_q + 1'b1;
        end
      end
    end
  end

  assign push_rec = {serve_sup, log_stamp, log_gap, log_fast};

  lu_guard_fifo #(.W(EW), .DEPTH(DEPTH)) u_queue (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (serve_any),
    .data_i (push_rec),
    .pop_i  (ev_pop_i),
    .valid_o(ev_valid_o),
    .data_o (head_rec)
  );

  assign ev_supply_o = head_rec[EW-1];
  assign ev_stamp_o  = head_rec[EW-2 -: TW];
  assign ev_gap_o    = head_rec[TW:1];
  assign ev_fast_o   = head_rec[0];
  assign locked_o    = locked_q;
  assign cnt_ana_o   = cnt_q[SUP_ANA];
  assign cnt_dig_o   = cnt_q[SUP_DIG];

  // R7: lockout only engages on a fast record
  a_r7_lock_on_fast: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(serve_any && log_fast));

  // R6: simultaneous commits are logged analog first, digital next
  a_r6_order: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_w[SUP_ANA] && commit_w[SUP_DIG]) |=> (serve_oh == 2'b01) ##1 (serve_oh == 2'b10));
endmodule

// File: tb/lu_guard_bench.sv
module lu_guard_bench;
  localparam int CLK_P = 10;
  localparam int TW = 16, HW = 8, CW = 3, DEPTH = 4, RC = 4, LN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] trip = 2'b00;
  logic [1:0] restore;
  logic [TW-1:0] free_q = '0, tb_fixed = '0, tbase;
  logic tb_run = 1'b0;
  logic [HW-1:0] holdoff = '0;
  logic [TW-1:0] min_gap = '0;
  logic lock_clr = 1'b0, pop = 1'b0;
  logic locked, ev_valid, ev_sup, ev_fast;
  logic [TW-1:0] ev_stamp, ev_gap;
  logic [CW-1:0] cnt_ana, cnt_dig;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) free_q <= free_q + 1'b1;
  assign tbase = tb_run ? free_q : tb_fixed;

  lu_guard #(.TW(TW), .HW(HW), .CW(CW), .DEPTH(DEPTH), .RESTORE_CYC(RC), .LOCK_N(LN)) u_lu_guard (
    .clk(clk), .rst_n(rst_n), .trip_i(trip), .restore_o(restore), .tbase_i(tbase),
    .holdoff_i(holdoff), .min_gap_i(min_gap), .lock_clr_i(lock_clr), .locked_o(locked),
    .ev_valid_o(ev_valid), .ev_pop_i(pop), .ev_supply_o(ev_sup), .ev_stamp_o(ev_stamp),
    .ev_gap_o(ev_gap), .ev_fast_o(ev_fast), .cnt_ana_o(cnt_ana), .cnt_dig_o(cnt_dig));

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; trip = 2'b00; pop = 1'b0; lock_clr = 1'b0; tb_run = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic fire(input int ch);
    int n = 0;
    trip[ch] = 1'b1;
    while (!restore[ch] && n < 200) begin @(negedge clk); n++; end
    if (!restore[ch]) chk("R4 restore seen", 0, 1);
    trip[ch] = 1'b0;
    n = 0;
    while (restore[ch] && n < 50) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic pop_one();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic chk_head(input string req, input int sup, input int stamp,
                          input int gap, input int fast);
    chk({req, " valid"}, ev_valid, 1);
    chk({req, " supply"}, ev_sup, sup);
    chk({req, " stamp"}, ev_stamp, stamp);
    chk({req, " gap"}, ev_gap, gap);
    chk({req, " fast"}, ev_fast, fast);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 restore", restore, 0);
    chk("R1 valid", ev_valid, 0);
    chk("R1 cnt_ana", cnt_ana, 0);
    chk("R1 cnt_dig", cnt_dig, 0);
    chk("R1 locked", locked, 0);
  endtask

  task automatic t_glitch();
    int seen = 0;
    do_reset();
    holdoff = 8'd1;
    trip[0] = 1'b1;
    @(negedge clk);
    trip[0] = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (restore[0]) seen++;
    end
    chk("R2 glitch no event", ev_valid, 0);
    chk("R2 glitch no count", cnt_ana, 0);
    chk("R2 glitch no restore", seen, 0);
    trip[0] = 1'b1;
    repeat (2) @(negedge clk);
    trip[0] = 1'b0;
    repeat (20) @(negedge clk);
    chk("R2 two samples commit", ev_valid, 1);
    chk("R2 two samples count", cnt_ana, 1);
  endtask

  task automatic t_holdoff(input int h);
    int n = 0, k = 0, len = 0;
    do_reset();
    holdoff = HW'(h);
    trip[0] = 1'b1;
    while (!ev_valid && n < 100) begin @(negedge clk); n++; end
    while (!restore[0] && k < 100) begin @(negedge clk); k++; end
    chk("R3 holdoff delay", k, h);
    trip[0] = 1'b0;
    while (restore[0] && len < 100) begin len++; @(negedge clk); end
    chk("R4 restore length", len, RC);
    repeat (4) @(negedge clk);
    fire(0);
    chk("R4 re-armed event", cnt_ana, 2);
  endtask

  task automatic t_record();
    do_reset();
    holdoff = 8'd1; min_gap = 16'd100;
    tb_fixed = 16'd50;  fire(0);
    tb_fixed = 16'd300; fire(1);
    tb_fixed = 16'd320; fire(1);
    chk_head("R5 first", 0, 50, 16'hFFFF, 0);  pop_one();
    chk_head("R5 second", 1, 300, 250, 0);     pop_one();
    chk_head("R7 short gap", 1, 320, 20, 1);   pop_one();
    chk("R9 drained", ev_valid, 0);
    tb_fixed = 16'd65531; fire(0);
    tb_fixed = 16'd10;    fire(0);
    chk_head("R5 long gap", 0, 65531, 65211, 0); pop_one();
    chk_head("R5 wrap gap", 0, 10, 15, 1);       pop_one();
  endtask

  task automatic t_simul();
    int n = 0;
    do_reset();
    holdoff = 8'd2; min_gap = 16'd10; tb_fixed = 16'd100;
    trip = 2'b11;
    while (!restore[0] && n < 100) begin @(negedge clk); n++; end
    chk("R6 both restores together", restore, 3);
    trip = 2'b00;
    repeat (12) @(negedge clk);
    chk_head("R6 analog first", 0, 100, 16'hFFFF, 0); pop_one();
    chk_head("R6 digital next", 1, 100, 0, 1);        pop_one();
    chk("R6 cnt_ana", cnt_ana, 1);
    chk("R6 cnt_dig", cnt_dig, 1);
  endtask

  task automatic t_full();
    do_reset();
    holdoff = 8'd0; min_gap = 16'd0;
    for (int i = 0; i < 5; i++) begin
      tb_fixed = TW'(10 * i);
      fire(0);
    end
    chk("R9 dropped record still counted", cnt_ana, 5);
    for (int i = 0; i < 4; i++) begin
      chk("R9 kept stamp", ev_stamp, 10 * i);
      pop_one();
    end
    chk("R9 overflow discarded", ev_valid, 0);
  endtask

  task automatic t_sat();
    do_reset();
    holdoff = 8'd0; min_gap = 16'd0;
    for (int i = 0; i < 9; i++) fire(1);
    chk("R10 saturated", cnt_dig, 7);
    chk("R10 other supply", cnt_ana, 0);
  endtask

  task automatic t_lock();
    int n = 0, hi = 0;
    do_reset();
    holdoff = 8'd3; min_gap = 16'd1000; tb_run = 1'b1;
    trip[0] = 1'b1;
    while (!locked && n < 500) begin @(negedge clk); n++; end
    chk("R8 lockout entered", locked, 1);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (restore[0]) hi++;
    end
    chk("R8 no restore while locked", hi, 0);
    chk("R8 event count at lock", cnt_ana, LN + 1);
    trip[0] = 1'b0;
    repeat (3) @(negedge clk);
    lock_clr = 1'b1;
    @(negedge clk);
    lock_clr = 1'b0;
    chk("R8 lockout cleared", locked, 0);
    hi = 0;
    for (int i = 0; i < 30; i++) begin
      if (restore[0]) hi++;
      @(negedge clk);
    end
    chk("R8 held restore completes", hi, RC);
    chk("R8 no new event", cnt_ana, LN + 1);
  endtask

  initial begin
    t_reset();
    t_glitch();
    t_holdoff(5);
    t_holdoff(0);
    t_record();
    t_simul();
    t_full();
    t_sat();
    t_lock();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule